// File: doc/BRIEF.md
# Vector Byte-Count Clear Unit

This unit takes a 128-bit vector made of sixteen bytes. It keeps a programmable number of those bytes at one end of the vector and forces every other byte to zero. The count comes from a 64-bit scalar operand. Only the low 32 bits of that operand are used, and they are read as a signed number. An 11-bit opcode chooses the end that survives. One opcode value keeps the rightmost bytes, which are the least significant. The other keeps the leftmost bytes, which are the most significant. Any other opcode is flagged as illegal and produces zero data.

Counts outside the range 1 to 16 saturate. A count above 16 passes the vector through untouched. A count of zero or any negative count clears the whole vector. With the default setting the result is registered: a valid strobe goes in with the operands, and the matching result comes out one cycle later with its own valid strobe. Setting `REG_OUT` to 0 makes the path purely combinational.

Top module: `vbclr_top`

## Requirements
- R1: With opcode 11'h18D and count N from 1 to 16, the output holds input bits [8N-1:0] unchanged and all higher bits are zero.
- R2: With opcode 11'h1CD and count N from 1 to 16, the output holds input bits [127:128-8N] unchanged and all lower bits are zero.
- R3: N is taken from count bits [31:0] only; bits [63:32] have no effect on the result.
- R4: When N, read as a signed 32-bit value, is greater than 16, the output equals the input vector for either legal opcode.
- R5: When N, read as a signed 32-bit value, is zero or negative, the output is all zeros for either legal opcode.
- R6: An accepted opcode other than 11'h18D and 11'h1CD raises `illegal_op` with the result and drives all-zero data; legal opcodes leave `illegal_op` low.
- R7: With `REG_OUT`=1, the result of operands accepted with `in_valid` high at a rising edge appears at the next edge, and `out_valid` is `in_valid` delayed by one cycle, including back-to-back operations.
- R8: While `out_valid` is low, `vec_out` is zero and `illegal_op` is low.
- R9: A synchronous active-high `rst` clears `out_valid`, `vec_out` and `illegal_op` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| opcode | input | 11 | Operation select: 11'h18D keeps the right end, 11'h1CD keeps the left end |
| vec_in | input | 128 | Source vector, bit 127 is in the leftmost byte |
| count_in | input | 64 | Scalar operand; the low 32 bits are the signed byte count |
| out_valid | output | 1 | Result valid |
| vec_out | output | 128 | Masked vector |
| illegal_op | output | 1 | Opcode was not recognised |

## Verification
The bench covers both ends of the count range. A count of 1 and a count of 16 expose off-by-one errors in the mask; a wrong shift would clear one byte too many or keep one byte too many. A count of 0, the most negative 32-bit value and the all-ones word must all give zero. A design that used an unsigned compare, or that let a 128-bit shift wrap around, would instead pass data through. Counts of 17 and 32'h7FFFFFFF must pass the vector through. Counts with nonzero upper operand bits catch a design that reads all 64 bits. An opcode that differs from a legal value in its top bit catches incomplete decoding. A gap in `in_valid` and a reset in mid-stream catch an output register that holds stale data.

// File: rtl/vbclr_pkg.sv
package vbclr_pkg;

    parameter int unsigned LANES     = 16;
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned VEC_W     = LANES * BYTE_W;
    parameter int unsigned OPC_W     = 11;
    parameter int unsigned SRC_W     = 64;
    parameter int unsigned CNT_W     = 32;
    parameter int unsigned KEEP_W    = $clog2(LANES + 1);

    localparam logic [OPC_W-1:0] OPC_KEEP_RIGHT = 11'h18D;
    localparam logic [OPC_W-1:0] OPC_KEEP_LEFT  = 11'h1CD;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RIGHT = 2'd1,
        SEL_LEFT  = 2'd2
    } sel_e;

    typedef struct packed {
        logic legal;
        sel_e sel;
    } dec_t;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] data;
    } res_t;

    // Saturate a signed count into the range 0..LANES.
    function automatic logic [KEEP_W-1:0] clamp_count(input logic signed [CNT_W-1:0] n);
        logic [KEEP_W-1:0] r;
        if (n > $signed(CNT_W'(LANES)))
            r = KEEP_W'(LANES);
        else if (n <= 0)
            r = '0;
        else
            r = n[KEEP_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/vbclr_decode.sv
module vbclr_decode
    import vbclr_pkg::*;
#(
    parameter int unsigned OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    output dec_t          dec
);
    always_comb begin
        dec = '{legal: 1'b0, sel: SEL_NONE};
        if (opcode == OPC_KEEP_RIGHT)
            dec = '{legal: 1'b1, sel: SEL_RIGHT};
        else if (opcode == OPC_KEEP_LEFT)
            dec = '{legal: 1'b1, sel: SEL_LEFT};
    end
endmodule

// File: rtl/vbclr_count.sv
module vbclr_count
    import vbclr_pkg::*;
#(
    parameter int unsigned SW = SRC_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned KW = KEEP_W
) (
    input  logic [SW-1:0] count_in,
    output logic [KW-1:0] keep_n
);
    logic signed [CW-1:0] n_s;

    always_comb begin
        n_s    = $signed(count_in[CW-1:0]);
        keep_n = clamp_count(n_s);
    end
endmodule

// File: rtl/vbclr_mask.sv
module vbclr_mask
    import vbclr_pkg::*;
#(
    parameter int unsigned NL = LANES,
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned KW = KEEP_W
) (
    input  sel_e             sel,
    input  logic [KW-1:0]    keep_n,
    output logic [NL*BW-1:0] mask
);
    localparam int unsigned SUM_W = KW + 1;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic keep_r, keep_l, keep;
        always_comb begin
            keep_r = (SUM_W'(keep_n) > SUM_W'(g));
            keep_l = (SUM_W'(keep_n) + SUM_W'(g)) >= SUM_W'(NL);
            unique case (sel)
                SEL_RIGHT: keep = keep_r;
                SEL_LEFT:  keep = keep_l;
                default:   keep = 1'b0;
            endcase
        end
        assign mask[g*BW +: BW] = {BW{keep}};
    end
endmodule

// File: rtl/vbclr_top.sv
module vbclr_top
    import vbclr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic [SRC_W-1:0]   count_in,
    output logic               out_valid,
    output logic [VEC_W-1:0]   vec_out,
    output logic               illegal_op
);
    dec_t              dec;
    logic [KEEP_W-1:0] keep_n;
    logic [VEC_W-1:0]  mask;
    res_t              res_c;

    vbclr_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    vbclr_count u_cnt (
        .count_in (count_in),
        .keep_n   (keep_n)
    );

    vbclr_mask u_mask (
        .sel    (dec.sel),
        .keep_n (keep_n),
        .mask   (mask)
    );

    always_comb begin
        res_c.valid   = in_valid;
        res_c.illegal = in_valid & ~dec.legal;
        res_c.data    = (in_valid && dec.legal) ? (vec_in & mask) : '0;
    end

    if (REG_OUT) begin : g_reg
        res_t res_q;
        always_ff @(posedge clk) begin
            if (rst)
                res_q <= '0;
            else
                res_q <= res_c;
        end
        assign out_valid  = res_q.valid;
        assign illegal_op = res_q.illegal;
        assign vec_out    = res_q.data;
    end else begin : g_comb
        assign out_valid  = res_c.valid;
        assign illegal_op = res_c.illegal;
        assign vec_out    = res_c.data;
    end
endmodule

// File: rtl/vbclr_chk.sv
module vbclr_chk
    import vbclr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OPC_W-1:0] opcode,
    input logic [VEC_W-1:0] vec_in,
    input logic [SRC_W-1:0] count_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic             illegal_op
);
    logic signed [CNT_W-1:0] n_s;
    logic                    op_ok;
    assign n_s   = $signed(count_in[CNT_W-1:0]);
    assign op_ok = (opcode == OPC_KEEP_RIGHT) || (opcode == OPC_KEEP_LEFT);

    if (REG_OUT) begin : g_seq
        p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
            !out_valid |-> (vec_out == '0 && !illegal_op));
        p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
            illegal_op |-> vec_out == '0);
        p_subset_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> ((vec_out & ~$past(vec_in)) == '0));
        p_pass_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_ok && n_s > 16) |=> vec_out == $past(vec_in));
        p_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && n_s <= 0) |=> vec_out == '0);
    end else begin : g_imm
        always_comb begin
            if (in_valid && !op_ok)
                a_illegal_zero_r6: assert (illegal_op && vec_out == '0);
            if (in_valid && n_s <= 0)
                a_zero_r5: assert (vec_out == '0);
            if (in_valid && op_ok && n_s > 16)
                a_pass_r4: assert (vec_out == vec_in);
            if (!in_valid)
                a_idle_zero_r8: assert (!out_valid && vec_out == '0);
        end
    end
endmodule

bind vbclr_top vbclr_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .vec_in     (vec_in),
    .count_in   (count_in),
    .out_valid  (out_valid),
    .vec_out    (vec_out),
    .illegal_op (illegal_op)
);

// File: tb/sim_vbclr_top.sv
`timescale 1ns/1ps
module sim_vbclr_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [10:0]  opcode;
    logic [127:0] vec_in;
    logic [63:0]  count_in;
    logic         out_valid;
    logic [127:0] vec_out;
    logic         illegal_op;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    vbclr_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .vec_in(vec_in), .count_in(count_in), .out_valid(out_valid),
        .vec_out(vec_out), .illegal_op(illegal_op)
    );

    localparam int NV = 16;
    // {opcode, count}
    localparam logic [74:0] TBL [NV] = '{
        {11'h18D, 64'd5},
        {11'h1CD, 64'd5},
        {11'h18D, 64'd1},
        {11'h1CD, 64'd1},
        {11'h18D, 64'd16},
        {11'h1CD, 64'd16},
        {11'h18D, 64'd15},
        {11'h1CD, 64'd17},
        {11'h18D, 64'd0},
        {11'h1CD, 64'h0000_0000_FFFF_FFFF},
        {11'h18D, 64'hFFFF_FFFF_0000_0008},
        {11'h1CD, 64'h0000_0001_0000_0003},
        {11'h18D, 64'h0000_0000_8000_0000},
        {11'h18D, 64'h0000_0000_7FFF_FFFF},
        {11'h000, 64'd4},
        {11'h5CD, 64'd4}
    };

    function automatic logic [127:0] pattern(input int i);
        logic [127:0] v;
        for (int k = 0; k < 16; k++)
            v[k*8 +: 8] = 8'((k * 16 + i * 3) | 1);
        return v;
    endfunction

    // Reference: build the kept region byte by byte from the chosen end.
    function automatic logic [127:0] model(input logic [10:0] op, input logic [63:0] c,
                                           input logic [127:0] v);
        logic [127:0] r = '0;
        int n = $signed(c[31:0]);
        if (op != 11'h18D && op != 11'h1CD) return '0;
        if (n > 16) return v;
        for (int k = 0; k < n; k++) begin
            if (op == 11'h18D) r[k*8 +: 8]        = v[k*8 +: 8];
            else               r[(15-k)*8 +: 8]   = v[(15-k)*8 +: 8];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [10:0] op, input logic [63:0] c);
        int n = $signed(c[31:0]);
        if (op != 11'h18D && op != 11'h1CD) return "R6";
        if (n > 16) return "R4";
        if (n <= 0) return "R5";
        if (c[63:32] != 0) return "R3";
        return (op == 11'h18D) ? "R1" : "R2";
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; in_valid = 0; opcode = '0; vec_in = '0; count_in = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "out_valid", 128'(out_valid), 128'd0);
        chk("R9", "vec_out", vec_out, '0);
        chk("R9", "illegal_op", 128'(illegal_op), 128'd0);
        rst = 0;

        // Table walk, back to back (R7): result checked one edge after drive.
        for (int i = 0; i < NV; i++) begin
            logic [10:0] op = TBL[i][74:64];
            logic [63:0] c  = TBL[i][63:0];
            logic [127:0] v = pattern(i);
            string t = tag_of(op, c);
            in_valid = 1; opcode = op; count_in = c; vec_in = v;
            @(negedge clk);
            chk("R7", "out_valid", 128'(out_valid), 128'd1);
            chk(t, "vec_out", vec_out, model(op, c, v));
            chk(t == "R6" ? "R6" : "R6_legal", "illegal_op", 128'(illegal_op),
                128'(t == "R6"));
        end

        // R8: idle cycle after stream, legal operands held on the inputs.
        in_valid = 0; opcode = 11'h18D; count_in = 64'd16; vec_in = pattern(3);
        @(negedge clk);
        chk("R8", "out_valid", 128'(out_valid), 128'd0);
        chk("R8", "vec_out", vec_out, '0);
        chk("R8", "illegal_op", 128'(illegal_op), 128'd0);

        // R3: same low word, different upper word, same result.
        in_valid = 1; opcode = 11'h1CD; count_in = 64'hDEAD_BEEF_0000_0007; vec_in = pattern(9);
        @(negedge clk);
        chk("R3", "vec_out", vec_out, model(11'h1CD, 64'd7, pattern(9)));

        // R9: reset while a valid operation is presented.
        rst = 1; opcode = 11'h18D; count_in = 64'd16;
        @(negedge clk);
        chk("R9", "out_valid mid", 128'(out_valid), 128'd0);
        chk("R9", "vec_out mid", vec_out, '0);
        rst = 0; in_valid = 0;
        @(negedge clk);
        finish_run();
    end
endmodule